// File: doc/BRIEF.md
# Converter Serial Master Output Port

This block takes the results of a decimating converter core and ships them to a host over a serial link on which the block always drives the bit clock. A free-running cadence counter marks a word boundary every 32 master-clock cycles. It raises a one-cycle data-ready pulse at each boundary, and on the same edge it moves the newest core result into a holding register.

The host owns the framing. It pulls its active-low frame request low. The block then drives the holding register's most significant bit onto the data line straight away. On the next rising master-clock edge it copies the word into a private shift register and starts a burst of 16 serial clocks, most significant bit first. Each bit changes just after a rising serial-clock edge, so the host samples on the falling edges. Because the serial clock is the master clock, gated, one bit moves per master-clock cycle. A full word therefore fits inside one 32-cycle word period.

When the host raises its request, the data line is released and the frame ends at once, even in the middle of a word. The next request starts again from the MSB of whatever word is then held.

The FSM has three states. TX_IDLE waits for a request. TX_SHIFT moves bits out. TX_DONE parks after the 16th bit until the request is withdrawn. Its transitions are:
- IDLE to SHIFT when the request is low.
- SHIFT to SHIFT while bits remain.
- SHIFT to DONE after the last bit.
- SHIFT to IDLE when the request rises (abort).
- DONE to IDLE when the request rises.

Top module: `conv_serial_tx`

## Requirements
- R1: `drdy_o` is high for exactly one master-clock cycle. It rises every 32 cycles, first on the 32nd rising edge after reset is released.
- R2: A `res_strobe_i` pulse stores `res_word_i`. The stored value reaches the holding register only on the edge where `drdy_o` rises. A strobe on that same edge is forwarded directly.
- R3: During a full frame, `sclk_o` shows exactly 16 falling edges.
- R4: A frame starts at the first rising clock edge that samples `frame_req_n_i` low. It ships the holding register's value from just before that edge.
- R5: The word is shifted MSB first. Bits change only after rising clock edges, so each bit is stable at the falling `sclk_o` edge where the host samples it.
- R6: While `frame_req_n_i` is low before the first shift edge, `sdata_o` already carries the held word's MSB.
- R7: `sdata_oe_o` is high exactly while `frame_req_n_i` is low. When it is low, `sdata_o` is 0.
- R8: A high `frame_req_n_i` sampled during a transfer stops shifting on that edge. The next frame restarts from the MSB of the then-current held word.
- R9: A holding-register update during a transfer does not alter the bits being shipped.
- R10: After the 16th bit, `sclk_o` stays high until a new frame begins.
- R11: During reset, `drdy_o` is 0, `sclk_o` is 1 and the FSM is in TX_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_word_i | input | 16 | Result word from the converter core |
| res_strobe_i | input | 1 | Result-valid strobe from the core |
| frame_req_n_i | input | 1 | Host frame request, active low |
| drdy_o | output | 1 | One-cycle data-ready pulse per word period |
| sclk_o | output | 1 | Serial bit clock, idle high |
| sdata_o | output | 1 | Serial data, MSB first |
| sdata_oe_o | output | 1 | Output enable of the serial data line |

## Verification
Several properties are checked on every cycle:
- the one-cycle width and the 32-cycle spacing of data-ready;
- the holding register staying frozen between pulses;
- no shift burst running longer than 16 cycles;
- a withdrawn request stopping the shifting on the following edge.

Other behaviour only the bench scenarios can show: the shipped bit order and values; the MSB appearing before the first shift; that a word latched mid-frame or a strobe without a data-ready leaves the shipped word alone; that an aborted frame restarts from the newest word's MSB; and the exact number of serial-clock falls per frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_DONE  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sertx_cadence.sv
module sertx_cadence #(
    parameter int PERIOD = 32,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] res_word,
    input  logic              res_strobe,
    output logic              drdy,
    output logic [WORD_W-1:0] hold_word
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0]     tick_q;
    logic              wrap;
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] fresh;

    assign wrap  = (tick_q == CW'(PERIOD - 1));
    // a strobe on the capture edge is forwarded, never lost
    assign fresh = res_strobe ? res_word : stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (wrap) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (res_strobe) begin
            stage_q <= res_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy      <= 1'b0;
            hold_word <= '0;
        end else begin
            drdy <= wrap;
            if (wrap) begin
                hold_word <= fresh;
            end
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_req_n,
    input  logic [WORD_W-1:0] hold_word,
    output logic              shift_en,
    output logic              tx_bit
);
    localparam int BW = $clog2(WORD_W);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic [BW-1:0]     bcnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              last_bit;

    assign last_bit = (bcnt_q == BW'(WORD_W - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (!frame_req_n) state_d = TX_SHIFT;
            TX_SHIFT: begin
                if (frame_req_n)   state_d = TX_IDLE;
                else if (last_bit) state_d = TX_DONE;
                else               state_d = TX_SHIFT;
            end
            TX_DONE:  if (frame_req_n) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bcnt_q  <= '0;
        end else if (state_q == TX_IDLE && state_d == TX_SHIFT) begin
            shreg_q <= hold_word;
            bcnt_q  <= '0;
        end else if (state_q == TX_SHIFT && state_d == TX_SHIFT) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
            bcnt_q  <= bcnt_q + 1'b1;
        end
    end

    always_comb begin
        shift_en = (state_q == TX_SHIFT);
        tx_bit   = (state_q == TX_IDLE) ? hold_word[WORD_W-1] : shreg_q[WORD_W-1];
    end
endmodule

// File: rtl/conv_serial_tx.sv
module conv_serial_tx #(
    parameter int PERIOD = 32,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] res_word_i,
    input  logic              res_strobe_i,
    input  logic              frame_req_n_i,
    output logic              drdy_o,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sdata_oe_o
);
    logic [WORD_W-1:0] hold_word;
    logic              shift_en;
    logic              tx_bit;

    sertx_cadence #(.PERIOD(PERIOD), .WORD_W(WORD_W)) cad_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_word   (res_word_i),
        .res_strobe (res_strobe_i),
        .drdy       (drdy_o),
        .hold_word  (hold_word)
    );

    sertx_shifter #(.WORD_W(WORD_W)) shf_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_req_n (frame_req_n_i),
        .hold_word   (hold_word),
        .shift_en    (shift_en),
        .tx_bit      (tx_bit)
    );

    // enable changes only while clk is high, so no spurious edge
    assign sclk_o     = shift_en ? clk : 1'b1;
    assign sdata_oe_o = ~frame_req_n_i;
    assign sdata_o    = sdata_oe_o & tx_bit;
endmodule

// File: rtl/conv_serial_tx_chk.sv
module conv_serial_tx_chk #(
    parameter int PERIOD = 32,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drdy_o,
    input logic              frame_req_n_i,
    input logic              shift_en,
    input logic [WORD_W-1:0] hold_word
);
    int unsigned gap_q;
    logic        seen_q;
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
            run_q  <= 0;
        end else begin
            gap_q <= drdy_o ? 0 : gap_q + 1;
            if (drdy_o) seen_q <= 1'b1;
            run_q <= shift_en ? run_q + 1 : 0;
        end
    end

    assert_drdy_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_o |=> !drdy_o);

    assert_drdy_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_o && seen_q) |-> gap_q == PERIOD - 1);

    assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_o |-> $stable(hold_word));

    assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> run_q < WORD_W);

    assert_abort_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req_n_i |=> !shift_en);
endmodule

bind conv_serial_tx conv_serial_tx_chk #(.PERIOD(PERIOD), .WORD_W(WORD_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .drdy_o        (drdy_o),
    .frame_req_n_i (frame_req_n_i),
    .shift_en      (shift_en),
    .hold_word     (hold_word)
);

// File: tb/conv_serial_tx_tb_top.sv
module conv_serial_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] res_word = '0;
    logic         res_strobe = 1'b0;
    logic         req_n = 1'b1;
    logic         drdy, sclk, sdata, sdata_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic [W-1:0] mon_acc = '0;
    int           mon_cnt = 0;
    int           falls   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_serial_tx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .res_word_i    (res_word),
        .res_strobe_i  (res_strobe),
        .frame_req_n_i (req_n),
        .drdy_o        (drdy),
        .sclk_o        (sclk),
        .sdata_o       (sdata),
        .sdata_oe_o    (sdata_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: the host samples serial data on each falling serial-clock edge
    always @(negedge sclk) begin
        falls++;
        mon_acc = {mon_acc[W-2:0], sdata};
        mon_cnt++;
        if (mon_cnt == W) begin
            mon_cnt = 0;
            if (exp_q.size() == 0) begin
                check("R5 unexpected word", {16'h0, mon_acc}, 32'hdead);
            end else begin
                check(tag_q.pop_front(), {16'h0, mon_acc}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic put_word(input logic [W-1:0] w);
        @(posedge clk); #1;
        res_word = w; res_strobe = 1'b1;
        @(posedge clk); #1;
        res_strobe = 1'b0;
    endtask

    task automatic wait_drdy();
        @(posedge drdy);
        @(posedge clk); #1;
    endtask

    task automatic frame_full(input logic [W-1:0] w, input string tag);
        int f0;
        exp_q.push_back(w);
        tag_q.push_back(tag);
        f0 = falls;
        req_n = 1'b0;
        #1;
        check("R6 MSB before shift", {31'h0, sdata}, {31'h0, w[W-1]});
        check("R7 oe while requested", {31'h0, sdata_oe}, 32'h1);
        repeat (20) @(posedge clk);
        #1;
        check("R3 falls per frame", falls - f0, 32'd16);
        check("R10 sclk parked high", {31'h0, sclk}, 32'h1);
        req_n = 1'b1;
        #1;
        check("R7 released oe", {31'h0, sdata_oe}, 32'h0);
        check("R7 released data", {31'h0, sdata}, 32'h0);
    endtask

    initial begin
        #(200000 * CLK_PERIOD);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        time t0;
        #2;
        check("R11 drdy in reset", {31'h0, drdy}, 32'h0);
        check("R11 sclk in reset", {31'h0, sclk}, 32'h1);
        check("R7 oe idle", {31'h0, sdata_oe}, 32'h0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: width and spacing of the data-ready pulse
        @(posedge drdy); t0 = $time;
        @(negedge clk);
        check("R1 drdy high", {31'h0, drdy}, 32'h1);
        @(negedge clk);
        check("R1 drdy one cycle", {31'h0, drdy}, 32'h0);
        @(posedge drdy);
        check("R1 drdy period", 32'($time - t0), 32'(32 * CLK_PERIOD));

        // R4/R5 basic frames with several patterns
        put_word(16'hA5C3);
        wait_drdy();
        frame_full(16'hA5C3, "R5 word A5C3");
        put_word(16'h8001);
        wait_drdy();
        frame_full(16'h8001, "R4 word 8001");

        // R2: strobe without data-ready leaves shipped word alone
        put_word(16'hFFFF);
        wait_drdy();
        put_word(16'h0000);
        frame_full(16'hFFFF, "R2 strobe not yet latched");

        // R9: frame spans a latch of a new word
        wait_drdy();
        put_word(16'h1234);
        repeat (24) @(posedge clk); #1;
        frame_full(16'h0000, "R9 old word kept");
        wait_drdy();
        frame_full(16'h1234, "R9 new word next frame");

        // R2: strobe on the capture edge is forwarded
        wait_drdy();
        repeat (30) @(posedge clk); #1;
        res_word = 16'h5A0F; res_strobe = 1'b1;
        @(posedge clk); #1;
        res_strobe = 1'b0;
        check("R1 drdy on capture edge", {31'h0, drdy}, 32'h1);
        @(posedge clk); #1;
        frame_full(16'h5A0F, "R2 same-edge strobe");

        // R8: abort mid word, restart from MSB of latest
        put_word(16'hC00C);
        wait_drdy();
        put_word(16'h3FF3);
        req_n = 1'b0;
        repeat (6) @(posedge clk); #1;
        req_n = 1'b1;
        @(posedge clk); #1;
        mon_cnt = 0; mon_acc = '0;
        check("R8 oe after abort", {31'h0, sdata_oe}, 32'h0);
        check("R8 sclk idle after abort", {31'h0, sclk}, 32'h1);
        wait_drdy();
        frame_full(16'h3FF3, "R8 restart from MSB");

        repeat (4) @(posedge clk);
        check("R5 scoreboard drained", exp_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule